// File: doc/BRIEF.md
# Bit-Addressable Memory Access Unit

This unit lets a requester read or write a single bit of a byte-wide data memory by naming it with a flat bit address. The bit address space has two windows. The lower window maps onto general data bytes starting at byte zero. The upper window maps onto special-function-register bytes at a separate base. The unit works out which byte holds the bit and which lane of that byte it occupies. It then drives a simple synchronous byte memory port, whose read data appears one cycle after the read strobe.

A bit read takes a single byte fetch, and the selected lane is returned with a one-cycle done pulse. A bit write is done as read-modify-write on the same port. The unit fetches the byte, replaces only the chosen lane with the new value, and writes the byte back to the same address. The unit handles one request at a time. Its ready output stays low from acceptance until the done cycle, so a request offered during that window is simply not taken.

Top module: `bitmem_access_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, req_ready is 1 and rsp_done, mem_rd_en and mem_wr_en are 0.
- R2: A bit address below 0x200 selects byte address (bit address >> 3) in the lower window.
- R3: A bit address of 0x200 or more selects byte address 0x400 + ((bit address - 0x200) >> 3).
- R4: The lane inside the byte is the low three bits of the adjusted bit address, where lane 0 is the least significant bit of mem_rdata/mem_wdata.
- R5: For a read accepted on a clock edge, mem_rd_en is 1 in the next cycle with the mapped byte address. In the cycle after that, rsp_done is 1 and rsp_bit equals the selected lane of mem_rdata. rsp_bit is 0 in every cycle that is not a read-done cycle.
- R6: A write with req_value 1 writes back the fetched byte with the selected lane set and all other lanes unchanged.
- R7: A write with req_value 0 writes back the fetched byte with the selected lane cleared and all other lanes unchanged.
- R8: A write asserts mem_wr_en in the cycle directly after its read, at the same byte address, and rsp_done is 1 in that write-back cycle. A read never asserts mem_wr_en.
- R9: rsp_done lasts exactly one cycle per accepted request.
- R10: req_ready is 0 from the cycle after acceptance through the done cycle. A request offered while req_ready is 0 is ignored: it causes no memory access and changes no byte.
- R11: mem_rd_en and mem_wr_en are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle; a request is taken on an edge where valid and ready are both 1 |
| req_bit_addr | input | 12 | Flat bit address |
| req_write | input | 1 | 1 = write the bit, 0 = read it |
| req_value | input | 1 | Bit value for a write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_bit | output | 1 | Bit read; valid when rsp_done is 1 for a read |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_addr | output | 11 | Byte address for read or write |
| mem_wdata | output | 8 | Byte written back |
| mem_rdata | input | 8 | Byte read data, valid one cycle after mem_rd_en |

## Verification
A new request can arrive in the same cycle that the previous write is being written back and reported done. The bench provokes this by raising a read of the just-written bit in the write-back cycle and holding it. It checks that the read is not taken until ready returns, and that the read then returns the freshly written value. A second case offers a foreign write only during the busy cycles and withdraws it before ready rises. The bench then checks that the memory port stays quiet and that the targeted byte keeps its old value.

// File: rtl/bitacc_pkg.sv
`timescale 1ns/1ps
package bitacc_pkg;

   typedef enum logic [1:0] {
      BA_IDLE  = 2'd0,
      BA_FETCH = 2'd1,
      BA_APPLY = 2'd2
   } ba_phase_e;

   typedef struct packed {
      logic write;
      logic wval;
   } ba_op_t;

endpackage

// File: rtl/bitacc_decode.sv
`timescale 1ns/1ps
module bitacc_decode #(
   parameter int          BIT_AW        = 12,
   parameter int          BYTE_AW       = 11,
   parameter int          DATA_W        = 8,
   parameter int unsigned SFR_BIT_BASE  = 'h200,
   parameter int unsigned SFR_BYTE_BASE = 'h400,
   parameter bit          SPLIT_EN      = 1'b1
) (
   input  logic [BIT_AW-1:0]          bit_addr,
   output logic [BYTE_AW-1:0]         byte_addr,
   output logic [$clog2(DATA_W)-1:0]  bit_pos
);
   localparam int POS_W = $clog2(DATA_W);
   localparam int IDX_W = BIT_AW - POS_W;

   // elaboration-time parameter checks
   if (DATA_W < 2 || (1 << POS_W) != DATA_W) begin : g_chk_dw
      $error("bitacc_decode: DATA_W must be a power of two >= 2");
   end
   if (IDX_W > BYTE_AW) begin : g_chk_aw
      $error("bitacc_decode: BYTE_AW too narrow for BIT_AW");
   end

   logic [BIT_AW-1:0] adj;

   if (SPLIT_EN) begin : g_split
      localparam logic [BIT_AW-1:0]  WIN_BIT  = BIT_AW'(SFR_BIT_BASE);
      localparam logic [BYTE_AW-1:0] WIN_BYTE = BYTE_AW'(SFR_BYTE_BASE);
      logic in_upper;
      logic [BYTE_AW-1:0] base;

      if ((SFR_BIT_BASE % DATA_W) != 0) begin : g_chk_align
         $error("bitacc_decode: upper window must start on a byte boundary");
      end

      assign in_upper  = (bit_addr >= WIN_BIT);
      assign adj       = in_upper ? (bit_addr - WIN_BIT) : bit_addr;
      assign base      = in_upper ? WIN_BYTE : '0;
      assign byte_addr = base + BYTE_AW'(adj[BIT_AW-1:POS_W]);
   end else begin : g_flat
      assign adj       = bit_addr;
      assign byte_addr = BYTE_AW'(adj[BIT_AW-1:POS_W]);
   end

   assign bit_pos = adj[POS_W-1:0];

endmodule

// File: rtl/bitacc_merge.sv
`timescale 1ns/1ps
module bitacc_merge #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]          rd_byte,
   input  logic [$clog2(DATA_W)-1:0]  bit_pos,
   input  logic                       new_val,
   output logic [DATA_W-1:0]          wr_byte,
   output logic                       sel_bit
);
   localparam int POS_W = $clog2(DATA_W);

   logic [DATA_W-1:0] lane_sel;

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      assign lane_sel[i] = (bit_pos == POS_W'(i));
      assign wr_byte[i]  = lane_sel[i] ? new_val : rd_byte[i];
   end

   assign sel_bit = |(rd_byte & lane_sel);

endmodule

// File: rtl/bitacc_ctrl.sv
`timescale 1ns/1ps
module bitacc_ctrl
   import bitacc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic op_write,
   output logic idle,
   output logic capture,
   output logic rd_strobe,
   output logic wr_strobe,
   output logic finish
);
   ba_phase_e phase_q, phase_d;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         BA_IDLE:  if (req_valid) phase_d = BA_FETCH;
         BA_FETCH: phase_d = BA_APPLY;
         BA_APPLY: phase_d = BA_IDLE;
         default:  phase_d = BA_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= BA_IDLE;
      else        phase_q <= phase_d;
   end

   assign idle      = (phase_q == BA_IDLE);
   assign capture   = idle & req_valid;
   assign rd_strobe = (phase_q == BA_FETCH);
   assign finish    = (phase_q == BA_APPLY);
   assign wr_strobe = finish & op_write;

endmodule

// File: rtl/bitmem_access_unit.sv
`timescale 1ns/1ps
module bitmem_access_unit
   import bitacc_pkg::*;
#(
   parameter int          BIT_AW        = 12,
   parameter int          BYTE_AW       = 11,
   parameter int          DATA_W        = 8,
   parameter int unsigned SFR_BIT_BASE  = 'h200,
   parameter int unsigned SFR_BYTE_BASE = 'h400,
   parameter bit          SPLIT_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [BIT_AW-1:0]  req_bit_addr,
   input  logic               req_write,
   input  logic               req_value,
   output logic               rsp_done,
   output logic               rsp_bit,
   output logic               mem_rd_en,
   output logic               mem_wr_en,
   output logic [BYTE_AW-1:0] mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata
);
   localparam int POS_W = $clog2(DATA_W);

   if (BIT_AW < POS_W + 1) begin : g_chk_bit_aw
      $error("bitmem_access_unit: BIT_AW too small");
   end
   if (SPLIT_EN && (SFR_BYTE_BASE >= (1 << BYTE_AW))) begin : g_chk_base
      $error("bitmem_access_unit: upper byte base outside byte space");
   end

   logic [BYTE_AW-1:0] dec_byte;
   logic [POS_W-1:0]   dec_pos;
   logic [BYTE_AW-1:0] hold_byte;
   logic [POS_W-1:0]   hold_pos;
   ba_op_t             hold_op;
   logic               capture;
   logic               finish;
   logic [DATA_W-1:0]  merged;
   logic               lane_val;

   // address map, evaluated on the incoming request
   bitacc_decode #(
      .BIT_AW       (BIT_AW),
      .BYTE_AW      (BYTE_AW),
      .DATA_W       (DATA_W),
      .SFR_BIT_BASE (SFR_BIT_BASE),
      .SFR_BYTE_BASE(SFR_BYTE_BASE),
      .SPLIT_EN     (SPLIT_EN)
   ) u_dec (
      .bit_addr (req_bit_addr),
      .byte_addr(dec_byte),
      .bit_pos  (dec_pos)
   );

   bitacc_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .op_write (hold_op.write),
      .idle     (req_ready),
      .capture  (capture),
      .rd_strobe(mem_rd_en),
      .wr_strobe(mem_wr_en),
      .finish   (finish)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_byte <= '0;
         hold_pos  <= '0;
         hold_op   <= '0;
      end else if (capture) begin
         hold_byte     <= dec_byte;
         hold_pos      <= dec_pos;
         hold_op.write <= req_write;
         hold_op.wval  <= req_value;
      end
   end

   bitacc_merge #(
      .DATA_W(DATA_W)
   ) u_merge (
      .rd_byte(mem_rdata),
      .bit_pos(hold_pos),
      .new_val(hold_op.wval),
      .wr_byte(merged),
      .sel_bit(lane_val)
   );

   assign mem_addr  = hold_byte;
   assign mem_wdata = mem_wr_en ? merged : '0;
   assign rsp_done  = finish;
   assign rsp_bit   = finish & ~hold_op.write & lane_val;

endmodule

// File: rtl/bitacc_chk.sv
`timescale 1ns/1ps
module bitacc_chk #(
   parameter int          BIT_AW        = 12,
   parameter int          BYTE_AW       = 11,
   parameter int          DATA_W        = 8,
   parameter int unsigned SFR_BIT_BASE  = 'h200,
   parameter int unsigned SFR_BYTE_BASE = 'h400,
   parameter bit          SPLIT_EN      = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [BIT_AW-1:0]  req_bit_addr,
   input logic               rsp_done,
   input logic               mem_rd_en,
   input logic               mem_wr_en,
   input logic [BYTE_AW-1:0] mem_addr,
   input logic [DATA_W-1:0]  mem_wdata,
   input logic [DATA_W-1:0]  mem_rdata
);
   localparam int POS_W = $clog2(DATA_W);

   function automatic logic [BYTE_AW-1:0] want_byte(input logic [BIT_AW-1:0] a);
      int unsigned v;
      v = int'(a);
      if (SPLIT_EN && v >= SFR_BIT_BASE)
         return BYTE_AW'(SFR_BYTE_BASE + ((v - SFR_BIT_BASE) >> POS_W));
      return BYTE_AW'(v >> POS_W);
   endfunction

   // R1: reset leaves the unit idle and the port quiet
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (req_ready && !rsp_done && !mem_rd_en && !mem_wr_en));

   // R2, R3: fetched byte follows the window map of the accepted address
   p_byte_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (mem_addr == want_byte($past(req_bit_addr))));

   // R5: a fetch is always followed by completion
   p_fetch_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> rsp_done);

   // R6, R7: write-back differs from the fetched byte in at most one lane
   p_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($countones(mem_wdata ^ mem_rdata) <= 1));

   // R8: write-back goes to the byte just read, in the done cycle
   p_wb_same_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (rsp_done && $past(mem_rd_en) && mem_addr == $past(mem_addr)));

   // R9: done is a single-cycle pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R10: acceptance makes the unit busy; it stays busy in the done cycle
   p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   p_busy_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !req_ready);

   // R11: read and write strobes are exclusive
   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

endmodule

bind bitmem_access_unit bitacc_chk #(
   .BIT_AW       (BIT_AW),
   .BYTE_AW      (BYTE_AW),
   .DATA_W       (DATA_W),
   .SFR_BIT_BASE (SFR_BIT_BASE),
   .SFR_BYTE_BASE(SFR_BYTE_BASE),
   .SPLIT_EN     (SPLIT_EN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_bit_addr(req_bit_addr),
   .rsp_done    (rsp_done),
   .mem_rd_en   (mem_rd_en),
   .mem_wr_en   (mem_wr_en),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_rdata   (mem_rdata)
);

// File: tb/sim_bitmem_access_unit.sv
`timescale 1ns/1ps
module sim_bitmem_access_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [11:0] req_bit_addr = '0;
   logic        req_write = 1'b0;
   logic        req_value = 1'b0;
   logic        rsp_done;
   logic        rsp_bit;
   logic        mem_rd_en;
   logic        mem_wr_en;
   logic [10:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   logic [7:0] mem     [2048];
   logic [7:0] ref_mem [2048];

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   bitmem_access_unit u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_bit_addr(req_bit_addr),
      .req_write   (req_write),
      .req_value   (req_value),
      .rsp_done    (rsp_done),
      .rsp_bit     (rsp_bit),
      .mem_rd_en   (mem_rd_en),
      .mem_wr_en   (mem_wr_en),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata)
   );

   // synchronous byte memory, one-cycle read latency
   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr];
      if (mem_wr_en) mem[mem_addr] <= mem_wdata;
   end

   function automatic logic [10:0] exp_byte(input logic [11:0] a);
      if (a >= 12'h200) return 11'h400 + 11'((a - 12'h200) >> 3);
      return 11'(a >> 3);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one complete access; req names the requirement under test
   task automatic access(input logic [11:0] a, input logic wr, input logic v,
                         input string req);
      logic [10:0] ba;
      logic [2:0]  pos;
      logic [7:0]  old_b;
      logic [7:0]  new_b;
      ba    = exp_byte(a);
      pos   = a[2:0];
      @(negedge clk);
      check("R10", "ready before request", 32'(req_ready), 1);
      req_valid    = 1'b1;
      req_bit_addr = a;
      req_write    = wr;
      req_value    = v;
      @(negedge clk);
      req_valid = 1'b0;
      check(req,   "read strobe", 32'(mem_rd_en), 1);
      check(req,   "byte address", 32'(mem_addr), 32'(ba));
      check("R10", "busy after accept", 32'(req_ready), 0);
      check("R11", "no write with read", 32'(mem_wr_en), 0);
      @(negedge clk);
      old_b      = ref_mem[ba];
      new_b      = old_b;
      new_b[pos] = v;
      check("R9", "done raised", 32'(rsp_done), 1);
      check("R10", "busy at done", 32'(req_ready), 0);
      if (wr) begin
         check("R8", "write strobe", 32'(mem_wr_en), 1);
         check("R8", "write address", 32'(mem_addr), 32'(ba));
         check(req,  "merged byte", 32'(mem_wdata), 32'(new_b));
         check("R5", "bit low on write done", 32'(rsp_bit), 0);
         ref_mem[ba] = new_b;
      end else begin
         check("R8", "no write on read", 32'(mem_wr_en), 0);
         check(req,  "bit value", 32'(rsp_bit), 32'(old_b[pos]));
      end
      @(negedge clk);
      check("R9",  "done one cycle", 32'(rsp_done), 0);
      check("R10", "ready again", 32'(req_ready), 1);
      check("R5",  "bit low when idle", 32'(rsp_bit), 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1", "ready in reset", 32'(req_ready), 1);
      check("R1", "done in reset", 32'(rsp_done), 0);
      check("R1", "strobes in reset", 32'({mem_rd_en, mem_wr_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "ready after reset", 32'(req_ready), 1);
      check("R1", "strobes after reset", 32'({mem_rd_en, mem_wr_en}), 0);
   endtask

   task automatic t_lower_reads;
      access(12'h000, 1'b0, 1'b0, "R2");
      access(12'h00F, 1'b0, 1'b0, "R4");
      access(12'h0A3, 1'b0, 1'b0, "R2");
      access(12'h1FF, 1'b0, 1'b0, "R2");
      for (int k = 0; k < 8; k++) access(12'(12'h040 + k), 1'b0, 1'b0, "R5");
   endtask

   task automatic t_upper_reads;
      access(12'h200, 1'b0, 1'b0, "R3");
      access(12'h207, 1'b0, 1'b0, "R4");
      access(12'h3A5, 1'b0, 1'b0, "R3");
      access(12'hFFF, 1'b0, 1'b0, "R3");
   endtask

   task automatic t_writes;
      access(12'h061, 1'b1, 1'b1, "R6");
      access(12'h061, 1'b0, 1'b0, "R5");
      access(12'h066, 1'b1, 1'b0, "R7");
      access(12'h066, 1'b0, 1'b0, "R5");
      access(12'h413, 1'b1, 1'b1, "R6");
      access(12'h413, 1'b0, 1'b0, "R5");
      access(12'h2F8, 1'b1, 1'b0, "R7");
      access(12'h2F8, 1'b0, 1'b0, "R5");
      access(12'h100, 1'b1, 1'b1, "R6");
      access(12'h100, 1'b1, 1'b1, "R6");
   endtask

   // a foreign write offered only while busy must be ignored
   task automatic t_busy_ignore;
      int strobes;
      logic [10:0] tb_byte;
      tb_byte = exp_byte(12'h050);
      @(negedge clk);
      req_valid = 1'b1; req_bit_addr = 12'h123; req_write = 1'b0; req_value = 1'b0;
      @(negedge clk);
      req_bit_addr = 12'h050; req_write = 1'b1;
      req_value    = ~ref_mem[tb_byte][0];
      @(negedge clk);
      check("R9", "done of first read", 32'(rsp_done), 1);
      check("R8", "no write for ignored", 32'(mem_wr_en), 0);
      req_valid = 1'b0;
      strobes = 0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         strobes += int'(mem_rd_en) + int'(mem_wr_en);
      end
      check("R10", "no access from ignored", 32'(strobes), 0);
      access(12'h050, 1'b0, 1'b0, "R10");
      check("R10", "target byte unchanged", 32'(mem[tb_byte]), 32'(ref_mem[tb_byte]));
   endtask

   // read of the written bit raised in the write-back cycle and held
   task automatic t_overlap;
      logic [10:0] ba;
      ba = exp_byte(12'h5C9);
      @(negedge clk);
      req_valid = 1'b1; req_bit_addr = 12'h5C9; req_write = 1'b1;
      req_value = ~ref_mem[ba][1];
      @(negedge clk);
      @(negedge clk);
      check("R8", "write-back in overlap", 32'(mem_wr_en), 1);
      ref_mem[ba][1] = req_value;
      req_write = 1'b0;
      @(negedge clk);
      check("R10", "held read not yet taken", 32'(mem_rd_en), 0);
      check("R10", "ready after write", 32'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      check("R5", "held read fetched", 32'(mem_rd_en), 1);
      @(negedge clk);
      check("R5", "read sees new bit", 32'(rsp_bit), 32'(ref_mem[ba][1]));
      check("R9", "done for held read", 32'(rsp_done), 1);
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) begin
         mem[i]     = 8'(i * 37 + 5);
         ref_mem[i] = 8'(i * 37 + 5);
      end
      t_reset();
      t_lower_reads();
      t_upper_reads();
      t_writes();
      t_busy_ignore();
      t_overlap();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule